// File: doc/BRIEF.md
# Asynchronous Interleaved Spike Sampler

This block turns sixteen rectified band signals into a single stream of non-overlapping stimulation events. Each channel keeps an accumulator that grows every clock by its input sample times a small per-channel gain. The accumulators race toward one shared threshold. The first channel to get there wins. It produces one pulse of programmable length on a shared event bus, and the pulse carries the channel index and the channel's 7-bit log-envelope value. When a channel wins, every accumulator is cleared and held at zero for as long as the pulse lasts. The winner then sits out a programmable refractory window.

Loud channels reach the threshold sooner, so they are sampled more often. Quiet channels are sampled rarely, and silence produces no events at all. Per-channel equalisation is set by the gain codes; the threshold itself is the same for every channel. The two time settings are 3-bit codes. A code c stands for (c+1) periods of a base prescaler of `PRE_DIV` clock cycles. With the default prescaler and a 50 MHz clock, the longest refractory code limits a channel to 1 kHz.

Top module: `spike_race_sampler`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, `ev_valid_o` is 0, `ev_chan_o` is 0 and `ev_env_o` is 0. All accumulators start at zero and no channel starts in refractory.
- R2: On each clock edge where a channel is free to accumulate, its accumulator grows by its `samp_i` byte multiplied by (g+1). Here g is the channel's 3-bit field in `gain_cfg_i`, and channel c owns bits [3c+2:3c].
- R3: An accumulator that would pass its all-ones value stops at all ones; it never wraps.
- R4: A channel competes when its registered accumulator is at or above `THRESH` and it is not refractory. On an edge with no event active, the lowest-numbered competing channel wins and its event starts. If no channel competes, no event starts.
- R5: An event holds `ev_valid_o` high for exactly (w+1)·`PRE_DIV` cycles, where w is `width_cfg_i`. Outside an event, the channel and envelope outputs are 0.
- R6: On the edge that starts an event, every accumulator is cleared, and all of them stay at zero until the event ends.
- R7: On the edge that ends its event, the winner enters refractory for (r+1)·`PRE_DIV` edges, where r is `refr_cfg_i`. During that time it neither accumulates nor competes. The countdown keeps running while other channels' events are active.
- R8: During an event, `ev_chan_o` shows the 0-based index of the winner, and `ev_env_o` shows the winner's 7-bit `env_i` field (bits [7c+6:7c]) as sampled on the winning edge. Both stay fixed for the whole event.
- R9: Two events never touch: at least one cycle with `ev_valid_o` low separates them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_i | input | N_CH*SAMP_W | Rectified samples, one byte per channel |
| env_i | input | N_CH*7 | Log-envelope values, 7 bits per channel |
| gain_cfg_i | input | N_CH*3 | Per-channel gain codes |
| width_cfg_i | input | 3 | Event width code |
| refr_cfg_i | input | 3 | Refractory length code |
| ev_valid_o | output | 1 | High for the duration of an event |
| ev_chan_o | output | 4 | Index of the winning channel |
| ev_env_o | output | 7 | Envelope value of the winner |

## Verification
The bench builds the block with a 10-bit accumulator, a threshold of 1000 and a prescaler of 3. With these values, one gained sample can overrun the accumulator, which exercises saturation. Event and refractory lengths come down to a few cycles, so many races, tie-breaks and refractory overlaps fit in a short run. A behavioural model predicts the event outputs on every clock. Directed scenarios also measure pulse lengths and the idle gaps between successive wins of a single channel.

// File: rtl/spk_pkg.sv
package spk_pkg;

    localparam int CODE_W     = 3;
    localparam int ENV_W      = 7;
    localparam int CHAN_IDX_W = 4;
    localparam int N_CH_DEF   = 16;

    typedef enum logic {
        SEQ_RACE  = 1'b0,
        SEQ_PULSE = 1'b1
    } seq_state_t;

    typedef struct packed {
        logic                  valid;
        logic [CHAN_IDX_W-1:0] chan;
        logic [ENV_W-1:0]      env;
    } spk_event_t;

    // Cycle count for a 3-bit time code: (code + 1) prescaler periods.
    function automatic int code_ticks(input logic [CODE_W-1:0] code, input int div);
        return (int'(code) + 1) * div;
    endfunction

endpackage

// File: rtl/spk_channel.sv
module spk_channel #(
    parameter int               SAMP_W = 8,
    parameter int               ACC_W  = 16,
    parameter int               CODE_W = 3,
    parameter int               CNT_W  = 8,
    parameter logic [ACC_W-1:0] THRESH = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SAMP_W-1:0] samp_i,
    input  logic [CODE_W-1:0] gain_i,
    input  logic              clear_i,
    input  logic              refr_load_i,
    input  logic [CNT_W-1:0]  refr_len_i,
    output logic              req_o
);
    localparam int MUL_W = SAMP_W + CODE_W + 1;
    localparam int SUM_W = ((ACC_W > MUL_W) ? ACC_W : MUL_W) + 1;
    localparam logic [ACC_W-1:0] ACC_MAX = '1;

    logic [ACC_W-1:0] acc_q, acc_d;
    logic [CNT_W-1:0] rcnt_q;
    logic             blocked;
    logic [CODE_W:0]  mult;
    logic [MUL_W-1:0] scaled;
    logic [SUM_W-1:0] sum;

    assign blocked = (rcnt_q != '0);
    assign mult    = {1'b0, gain_i} + {{CODE_W{1'b0}}, 1'b1};
    assign scaled  = MUL_W'(samp_i) * MUL_W'(mult);
    assign sum     = SUM_W'(acc_q) + SUM_W'(scaled);

    always_comb begin
        if (clear_i || blocked) begin
            acc_d = '0;
        end else if (sum > SUM_W'(ACC_MAX)) begin
            acc_d = ACC_MAX;
        end else begin
            acc_d = sum[ACC_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            rcnt_q <= '0;
        end else begin
            acc_q <= acc_d;
            if (refr_load_i) begin
                rcnt_q <= refr_len_i;
            end else if (blocked) begin
                rcnt_q <= rcnt_q - 1'b1;
            end
        end
    end

    assign req_o = !blocked && (acc_q >= THRESH);

    AST_ACC_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!clear_i && !blocked) |=> (acc_q >= $past(acc_q))); // R3
    AST_CLEAR_HOLDS: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (acc_q == '0)); // R6
    AST_REFR_SILENT: assert property (@(posedge clk) disable iff (rst)
        blocked |-> (acc_q == '0 && !req_o)); // R7

endmodule

// File: rtl/spk_prio_pick.sv
module spk_prio_pick #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     req_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = IDX_W'(i);
            end
        end
    end

    assign any_o = |req_i;

endmodule

// File: rtl/spk_sequencer.sv
module spk_sequencer import spk_pkg::*; #(
    parameter int CNT_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  win_i,
    input  logic [CHAN_IDX_W-1:0] win_idx_i,
    input  logic [ENV_W-1:0]      win_env_i,
    input  logic [CNT_W-1:0]      plen_i,
    output logic                  busy_o,
    output logic                  done_o,
    output spk_event_t            ev_o
);
    seq_state_t            state_q;
    logic [CNT_W-1:0]      pcnt_q;
    logic [CHAN_IDX_W-1:0] idx_q;
    logic [ENV_W-1:0]      env_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_RACE;
            pcnt_q  <= '0;
            idx_q   <= '0;
            env_q   <= '0;
        end else begin
            case (state_q)
                SEQ_RACE: begin
                    if (win_i) begin
                        state_q <= SEQ_PULSE;
                        pcnt_q  <= plen_i - 1'b1;
                        idx_q   <= win_idx_i;
                        env_q   <= win_env_i;
                    end
                end
                SEQ_PULSE: begin
                    if (pcnt_q == '0) begin
                        state_q <= SEQ_RACE;
                    end else begin
                        pcnt_q <= pcnt_q - 1'b1;
                    end
                end
                default: state_q <= SEQ_RACE;
            endcase
        end
    end

    assign busy_o   = (state_q == SEQ_PULSE);
    assign done_o   = busy_o && (pcnt_q == '0);
    assign ev_o.valid = busy_o;
    assign ev_o.chan  = busy_o ? idx_q : '0;
    assign ev_o.env   = busy_o ? env_q : '0;

    AST_EV_GAP: assert property (@(posedge clk) disable iff (rst)
        $fell(ev_o.valid) |=> !ev_o.valid); // R9
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !ev_o.valid |-> (ev_o.chan == '0 && ev_o.env == '0)); // R5
    AST_EV_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ev_o.valid && $past(ev_o.valid)) |-> ($stable(ev_o.chan) && $stable(ev_o.env))); // R8

endmodule

// File: rtl/spike_race_sampler.sv
module spike_race_sampler import spk_pkg::*; #(
    parameter int               N_CH    = N_CH_DEF,
    parameter int               SAMP_W  = 8,
    parameter int               ACC_W   = 16,
    parameter logic [ACC_W-1:0] THRESH  = 16'd20000,
    parameter int               PRE_DIV = 6250
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [N_CH*SAMP_W-1:0]     samp_i,
    input  logic [N_CH*ENV_W-1:0]      env_i,
    input  logic [N_CH*CODE_W-1:0]     gain_cfg_i,
    input  logic [CODE_W-1:0]          width_cfg_i,
    input  logic [CODE_W-1:0]          refr_cfg_i,
    output logic                       ev_valid_o,
    output logic [CHAN_IDX_W-1:0]      ev_chan_o,
    output logic [ENV_W-1:0]           ev_env_o
);
    localparam int MAX_TICKS = (1 << CODE_W) * PRE_DIV;
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);

    logic [N_CH-1:0]       req;
    logic [N_CH-1:0]       refr_load;
    logic                  any_req, win, busy, done;
    logic [CHAN_IDX_W-1:0] pick_idx;
    logic [ENV_W-1:0]      pick_env;
    logic [CNT_W-1:0]      plen, rlen;
    spk_event_t            ev;

    assign plen = CNT_W'(code_ticks(width_cfg_i, PRE_DIV));
    assign rlen = CNT_W'(code_ticks(refr_cfg_i, PRE_DIV));

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        assign refr_load[c] = done && (ev.chan == CHAN_IDX_W'(c));

        spk_channel #(
            .SAMP_W (SAMP_W),
            .ACC_W  (ACC_W),
            .CODE_W (CODE_W),
            .CNT_W  (CNT_W),
            .THRESH (THRESH)
        ) u_ch (
            .clk         (clk),
            .rst         (rst),
            .samp_i      (samp_i[c*SAMP_W +: SAMP_W]),
            .gain_i      (gain_cfg_i[c*CODE_W +: CODE_W]),
            .clear_i     (win || busy),
            .refr_load_i (refr_load[c]),
            .refr_len_i  (rlen),
            .req_o       (req[c])
        );
    end

    spk_prio_pick #(
        .N     (N_CH),
        .IDX_W (CHAN_IDX_W)
    ) u_pick (
        .req_i (req),
        .any_o (any_req),
        .idx_o (pick_idx)
    );

    assign win      = any_req && !busy;
    assign pick_env = env_i[pick_idx*ENV_W +: ENV_W];

    spk_sequencer #(
        .CNT_W (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .win_i     (win),
        .win_idx_i (pick_idx),
        .win_env_i (pick_env),
        .plen_i    (plen),
        .busy_o    (busy),
        .done_o    (done),
        .ev_o      (ev)
    );

    assign ev_valid_o = ev.valid;
    assign ev_chan_o  = ev.chan;
    assign ev_env_o   = ev.env;

    AST_WIN_IS_REQ: assert property (@(posedge clk) disable iff (rst)
        win |-> req[pick_idx]); // R4
    AST_WIN_LOWEST: assert property (@(posedge clk) disable iff (rst)
        win |-> ((req & ((N_CH'(1) << pick_idx) - N_CH'(1))) == '0)); // R4
    AST_WIN_STARTS: assert property (@(posedge clk) disable iff (rst)
        win |=> (ev_valid_o && ev_chan_o == $past(pick_idx))); // R8

endmodule

// File: tb/tb_spike_race_sampler.sv
module tb_spike_race_sampler;
    localparam int N      = 16;
    localparam int SW     = 8;
    localparam int EW     = 7;
    localparam int AW     = 10;
    localparam int TH     = 1000;
    localparam int DIV    = 3;
    localparam int AMAX   = (1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N*SW-1:0] samp_flat = '0;
    logic [N*EW-1:0] env_flat  = '0;
    logic [N*3-1:0]  gain_flat = '0;
    logic [2:0]      width_cfg = 3'd2;
    logic [2:0]      refr_cfg  = 3'd4;
    logic            ev_valid;
    logic [3:0]      ev_chan;
    logic [6:0]      ev_env;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit rand_mode = 1'b0;

    // reference model state
    int m_acc[N];
    int m_rc[N];
    bit m_pulse;
    int m_pcnt, m_win, m_env;

    // run observation
    bit prev_valid = 1'b0;
    int ev_count, first_chan, last_chan, hi_run, lo_run, last_hi, last_lo;

    always #10 clk = ~clk;

    spike_race_sampler #(
        .N_CH    (N),
        .SAMP_W  (SW),
        .ACC_W   (AW),
        .THRESH  (10'd1000),
        .PRE_DIV (DIV)
    ) dut (
        .clk         (clk),
        .rst         (rst),
        .samp_i      (samp_flat),
        .env_i       (env_flat),
        .gain_cfg_i  (gain_flat),
        .width_cfg_i (width_cfg),
        .refr_cfg_i  (refr_cfg),
        .ev_valid_o  (ev_valid),
        .ev_chan_o   (ev_chan),
        .ev_env_o    (ev_env)
    );

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic model_step();
        int win;
        bit starting, ending;
        int old_rc, s, g, v;
        if (rst) begin
            for (int c = 0; c < N; c++) begin
                m_acc[c] = 0;
                m_rc[c]  = 0;
            end
            m_pulse = 1'b0; m_pcnt = 0; m_win = 0; m_env = 0;
        end else begin
            win = -1;
            for (int c = 0; c < N; c++)
                if (win < 0 && m_rc[c] == 0 && m_acc[c] >= TH) win = c;
            starting = !m_pulse && (win >= 0);
            ending   = m_pulse && (m_pcnt == 0);
            for (int c = 0; c < N; c++) begin
                old_rc = m_rc[c];
                if (m_pulse || starting || old_rc != 0) begin
                    m_acc[c] = 0;
                end else begin
                    s = int'(samp_flat[c*SW +: SW]);
                    g = int'(gain_flat[c*3 +: 3]);
                    v = m_acc[c] + s * (g + 1);
                    m_acc[c] = (v > AMAX) ? AMAX : v;
                end
                if (ending && c == m_win) m_rc[c] = (int'(refr_cfg) + 1) * DIV;
                else if (old_rc > 0)       m_rc[c] = old_rc - 1;
            end
            if (starting) begin
                m_pulse = 1'b1;
                m_pcnt  = (int'(width_cfg) + 1) * DIV - 1;
                m_win   = win;
                m_env   = int'(env_flat[win*EW +: EW]);
            end else if (m_pulse) begin
                if (m_pcnt == 0) m_pulse = 1'b0;
                else             m_pcnt--;
            end
        end
    endtask

    task automatic compare();
        int ec, ee;
        ec = m_pulse ? m_win : 0;
        ee = m_pulse ? m_env : 0;
        check(ev_valid == m_pulse, "R2/R4/R5/R6/R7/R9 valid", int'(ev_valid), int'(m_pulse));
        check(int'(ev_chan) == ec, "R4/R8 chan", int'(ev_chan), ec);
        check(int'(ev_env) == ee, "R8 env", int'(ev_env), ee);
    endtask

    task automatic observe();
        if (ev_valid && !prev_valid) begin
            if (ev_count == 0) first_chan = int'(ev_chan);
            last_chan = int'(ev_chan);
            ev_count++;
            last_lo = lo_run;
            hi_run = 1;
        end else if (ev_valid) begin
            hi_run++;
        end else if (prev_valid) begin
            last_hi = hi_run;
            lo_run = 1;
        end else begin
            lo_run++;
        end
        prev_valid = ev_valid;
    endtask

    task automatic clear_obs();
        ev_count = 0; first_chan = -1; last_chan = -1;
        last_hi = 0; last_lo = 0;
    endtask

    task automatic tick();
        @(negedge clk);
        model_step();
        compare();
        observe();
        for (int c = 0; c < N; c++) begin
            env_flat[c*EW +: EW] = EW'($urandom);
            if (rand_mode) begin
                samp_flat[c*SW +: SW] = SW'($urandom_range(0, 40));
                gain_flat[c*3 +: 3]   = 3'($urandom);
            end
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic set_ch(input int c, input int s, input int g);
        samp_flat[c*SW +: SW] = SW'(s);
        gain_flat[c*3 +: 3]   = 3'(g);
    endtask

    task automatic quiet_all();
        samp_flat = '0;
        gain_flat = '0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R5 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        clear_obs();
        run(4);
        check(ev_valid == 1'b0 && ev_chan == 4'd0 && ev_env == 7'd0,
              "R1 reset outputs", int'({ev_valid, ev_chan, ev_env}), 0);
        rst = 1'b0;
        run(1);
        check(ev_valid == 1'b0, "R1 first cycle after reset", int'(ev_valid), 0);

        // silence produces no events
        clear_obs();
        run(50);
        check(ev_count == 0, "R4 no event without crossing", ev_count, 0);

        // single channel, unity gain: width 9 cycles, low gap 15+10+1
        clear_obs();
        set_ch(5, 100, 0);
        run(120);
        check(last_chan == 5, "R8 winner index", last_chan, 5);
        check(last_hi == 9, "R5 pulse length", last_hi, 9);
        check(last_lo == 26, "R7 refractory gap", last_lo, 26);

        // gain 4 gives x5: two additions reach the threshold
        quiet_all(); run(40);
        clear_obs();
        set_ch(5, 100, 4);
        run(120);
        check(last_lo == 18, "R2 gain scaling gap", last_lo, 18);

        // tie between channels 2 and 11
        quiet_all(); run(40);
        clear_obs();
        set_ch(2, 250, 0);
        set_ch(11, 250, 0);
        run(40);
        check(first_chan == 2, "R4 lowest index wins tie", first_chan, 2);
        check(ev_count >= 2, "R7 refractory lets the other channel win", ev_count, 2);

        // saturation: one addition of 1040 clips to 1023
        quiet_all(); run(40);
        clear_obs();
        set_ch(7, 130, 7);
        run(80);
        check(ev_count > 0 && last_chan == 7, "R3 saturated accumulator wins", last_chan, 7);
        check(last_lo == 17, "R3 one-step saturation gap", last_lo, 17);

        // longer pulse and shorter refractory
        quiet_all(); run(40);
        width_cfg = 3'd5;
        refr_cfg  = 3'd0;
        clear_obs();
        set_ch(9, 200, 1);
        run(100);
        check(last_hi == 18, "R5 pulse length code 5", last_hi, 18);
        check(last_lo == 3 + 3 + 1, "R7 refractory code 0 gap", last_lo, 7);

        // random traffic on all channels, configs changed now and then
        quiet_all(); run(40);
        rand_mode = 1'b1;
        for (int k = 0; k < 6; k++) begin
            width_cfg = 3'($urandom);
            refr_cfg  = 3'($urandom);
            clear_obs();
            run(500);
            check(ev_count > 0, "R4 random traffic produces events", ev_count, 1);
        end
        rand_mode = 1'b0;

        // reset in the middle of activity
        rst = 1'b1;
        run(2);
        check(ev_valid == 1'b0 && ev_chan == 4'd0, "R1 reset mid-run", int'(ev_valid), 0);
        rst = 1'b0;
        run(5);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule